// File: doc/BRIEF.md
# Multi-Source Interrupt Flag Controller

This block gathers completion and status events from the engines of a network controller. The engines are a modular exponentiation unit, a hash unit, a block cipher, a DMA mover, the transmitter, the PHY link monitor and the receive packet counter. It records these events as flag bits in one register and masks them with a matching enable register.

The three start/busy bits and the transmit-request bit raise their flag when they fall. The hash engine raises its flag with a one-cycle done pulse. The link flag rises on any change of the link level. The packet flag is not latched: it is a live view of a nonzero packet count.

Software reads and writes the registers through a small synchronous port. Address 0 is the flags, address 1 is the enables and address 2 is a read-only status view. Software clears latched flags by writing ones to them. A single active-low interrupt line is driven whenever the global enable is on and any enabled flag is set.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the flag register reads 0, the enable register reads 0 and irqN is 1. Input levels present at reset release produce no flag.
- R2: Writing address 1 stores only bits 15 (global), 14, 13, 12, 11, 6, 5 and 3. All other enable bits read as 0.
- R3: A 1-to-0 transition of modexBusy, aesBusy, dmaBusy or txReq sets flag bit 14, 12, 5 or 3 respectively. The flag is readable one clock after the edge is sampled. A 0-to-1 transition sets nothing.
- R4: Each clock edge with hashDone high sets flag bit 13.
- R5: Any change of linkUp, rising or falling, sets flag bit 11. Address 2 reads linkUp at bit 8 and pktCount at bits 7:0, with all other bits 0.
- R6: Flag bit 6 reads 1 exactly while pktCount is nonzero. Writes do not affect it.
- R7: Writing address 0 clears each latched flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R8: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: irqN is 0 exactly when enable bit 15 is 1 and some flag bit is 1 with its enable bit also 1. Otherwise irqN is 1.
- R10: While enable bit 15 is 0, irqN stays 1 whatever the flags and individual enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 flags, 1 enables, 2 status |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| modexBusy | input | 1 | Modular exponentiation busy |
| hashDone | input | 1 | Hash block/calculation done pulse |
| aesBusy | input | 1 | Cipher busy |
| dmaBusy | input | 1 | DMA copy/checksum busy |
| txReq | input | 1 | Transmit request pending |
| linkUp | input | 1 | PHY link level |
| pktCount | input | 8 | Received packets awaiting software |
| irqN | output | 1 | Active-low interrupt |

## Verification
Busy lines are dropped one at a time and two at once. This separates the per-source bit positions and shows that simultaneous events merge. A rising transmit request shows that only falling edges count. The link is toggled in both directions to cover both edges, and a link level held high through reset must leave no flag. Partial, full and colliding clearing writes separate write-one-to-clear from the set-over-clear priority and from the unwritable packet bit. Different enable patterns, with and without the global bit, show which flag terms reach irqN.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int REG_W = 16;
  localparam int CNT_W = 8;
  localparam int ADDR_W = 2;

  localparam int GLOBAL_BIT = 15;
  localparam int MODEX_BIT  = 14;
  localparam int HASH_BIT   = 13;
  localparam int AES_BIT    = 12;
  localparam int LINK_BIT   = 11;
  localparam int PKT_BIT    = 6;
  localparam int DMA_BIT    = 5;
  localparam int TX_BIT     = 3;
  localparam int LINK_STAT_BIT = 8;

  // busy-type sources, falling edge sets the flag at the listed position
  localparam int N_BUSY = 4;
  localparam int BUSY_BIT [N_BUSY] = '{MODEX_BIT, AES_BIT, DMA_BIT, TX_BIT};

  localparam logic [REG_W-1:0] LATCH_MASK =
      (REG_W'(1) << MODEX_BIT) | (REG_W'(1) << HASH_BIT) | (REG_W'(1) << AES_BIT) |
      (REG_W'(1) << LINK_BIT)  | (REG_W'(1) << DMA_BIT)  | (REG_W'(1) << TX_BIT);
  localparam logic [REG_W-1:0] ENABLE_MASK =
      LATCH_MASK | (REG_W'(1) << PKT_BIT) | (REG_W'(1) << GLOBAL_BIT);

  typedef enum logic [ADDR_W-1:0] {
    ADDR_FLAG   = 2'd0,
    ADDR_ENABLE = 2'd1,
    ADDR_STATUS = 2'd2
  } regAddr_e;

  typedef struct packed {
    logic [REG_W-1:0] setVec;
    logic             flagWr;
    logic             enWr;
    logic [REG_W-1:0] wrData;
  } strobes_t;
endpackage

// File: rtl/irq_flag_ctl.sv
`timescale 1ns/1ps
module irq_flag_ctl
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modexBusy,
  input  logic              hashDone,
  input  logic              aesBusy,
  input  logic              dmaBusy,
  input  logic              txReq,
  input  logic              linkUp,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output strobes_t          strobes
);
  logic [N_BUSY-1:0] busyNow;
  logic [N_BUSY-1:0] busyPrev;
  logic [N_BUSY-1:0] busyFall;
  logic              linkPrev;
  logic              armed;

  assign busyNow = {txReq, dmaBusy, aesBusy, modexBusy};

  // history registers; armed stays low for the first edge so levels present
  // at reset release are taken as the starting point, not as an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyPrev <= '0;
      linkPrev <= 1'b0;
      armed    <= 1'b0;
    end else begin
      busyPrev <= busyNow;
      linkPrev <= linkUp;
      armed    <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < N_BUSY; g++) begin : g_fall
      assign busyFall[g] = armed & busyPrev[g] & ~busyNow[g];
    end
  endgenerate

  always_comb begin
    strobes.setVec = '0;
    for (int i = 0; i < N_BUSY; i++) begin
      if (busyFall[i]) strobes.setVec = strobes.setVec | (REG_W'(1) << BUSY_BIT[i]);
    end
    if (hashDone)                   strobes.setVec = strobes.setVec | (REG_W'(1) << HASH_BIT);
    if (armed && (linkPrev ^ linkUp)) strobes.setVec = strobes.setVec | (REG_W'(1) << LINK_BIT);
    strobes.flagWr = regWrEn && (regAddr == ADDR_FLAG);
    strobes.enWr   = regWrEn && (regAddr == ADDR_ENABLE);
    strobes.wrData = regWrData;
  end

  // R3
  modex_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(modexBusy) && !modexBusy) |-> strobes.setVec[MODEX_BIT]);
  // R3
  tx_rise_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !$past(txReq) && txReq) |-> !strobes.setVec[TX_BIT]);
  // R5
  link_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ($past(linkUp) != linkUp)) |-> strobes.setVec[LINK_BIT]);
  // R1
  no_early_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !strobes.setVec[LINK_BIT]);
endmodule

// File: rtl/irq_flag_dp.sv
`timescale 1ns/1ps
module irq_flag_dp
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic              linkUp,
  input  logic [CNT_W-1:0]  pktCount,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [REG_W-1:0]  regRdData,
  output logic              irqN
);
  logic [REG_W-1:0] flagView;
  logic [REG_W-1:0] enReg;
  logic [REG_W-1:0] statusView;
  logic             pending;

  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      if (LATCH_MASK[b]) begin : g_latch
        logic bitQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)                                bitQ <= 1'b0;
          else if (strobes.setVec[b])               bitQ <= 1'b1;
          else if (strobes.flagWr && strobes.wrData[b]) bitQ <= 1'b0;
        end
        assign flagView[b] = bitQ;

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
          strobes.setVec[b] |=> flagView[b]);
        // R7
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
          (strobes.flagWr && strobes.wrData[b] && !strobes.setVec[b]) |=> !flagView[b]);
        // R7
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
          (flagView[b] && !(strobes.flagWr && strobes.wrData[b])) |=> flagView[b]);
      end else if (b == PKT_BIT) begin : g_live
        assign flagView[b] = |pktCount;
      end else begin : g_none
        assign flagView[b] = 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enReg <= '0;
    else if (strobes.enWr) enReg <= strobes.wrData & ENABLE_MASK;
  end

  assign statusView = REG_W'(pktCount) | (REG_W'(linkUp) << LINK_STAT_BIT);

  always_comb begin
    case (regAddr)
      ADDR_FLAG:   regRdData = flagView;
      ADDR_ENABLE: regRdData = enReg;
      ADDR_STATUS: regRdData = statusView;
      default:     regRdData = '0;
    endcase
  end

  assign pending = |(flagView & enReg);
  assign irqN    = ~(enReg[GLOBAL_BIT] & pending);

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enReg[GLOBAL_BIT] |-> irqN);
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              modexBusy,
  input  logic              hashDone,
  input  logic              aesBusy,
  input  logic              dmaBusy,
  input  logic              txReq,
  input  logic              linkUp,
  input  logic [CNT_W-1:0]  pktCount,
  output logic              irqN
);
  strobes_t strobes;

  irq_flag_ctl ctl_i (
    .clk(clk), .rstN(rstN),
    .modexBusy(modexBusy), .hashDone(hashDone), .aesBusy(aesBusy),
    .dmaBusy(dmaBusy), .txReq(txReq), .linkUp(linkUp),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobes(strobes)
  );

  irq_flag_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .linkUp(linkUp), .pktCount(pktCount), .regAddr(regAddr),
    .regRdData(regRdData), .irqN(irqN)
  );
endmodule

// File: tb/irq_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_flag_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        modexBusy, hashDone, aesBusy, dmaBusy, txReq, linkUp;
  logic [7:0]  pktCount;
  logic        irqN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [1:0]  addr;
    logic [15:0] val;
    logic        irq;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  irq_flag_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .modexBusy(modexBusy), .hashDone(hashDone), .aesBusy(aesBusy),
    .dmaBusy(dmaBusy), .txReq(txReq), .linkUp(linkUp),
    .pktCount(pktCount), .irqN(irqN)
  );

  // driver side: select the register and queue what it must read
  task automatic expect_reg(input logic [1:0] a, input logic [15:0] v,
                            input logic irq, input string tag);
    @(negedge clk);
    regAddr = a;
    sbq.push_back('{addr: a, val: v, irq: irq, tag: tag});
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // monitor side: compare queued expectations with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      while (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        checks++;
        if (regRdData !== it.val || irqN !== it.irq) begin
          errors++;
          $display("FAIL %s: addr=%0d data=%h irqN=%b, expected data=%h irqN=%b",
                   it.tag, it.addr, regRdData, irqN, it.val, it.irq);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog (R1..all): run still going, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 2'd0; regWrData = 16'h0;
    modexBusy = 1'b1; aesBusy = 1'b1; dmaBusy = 1'b1; txReq = 1'b0;
    hashDone = 1'b0; linkUp = 1'b1; pktCount = 8'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    expect_reg(2'd0, 16'h0000, 1'b1, "R1 flags after reset");
    expect_reg(2'd1, 16'h0000, 1'b1, "R1 enables after reset");
    expect_reg(2'd2, 16'h0100, 1'b1, "R5 status link high count 0");

    wr_reg(2'd1, 16'h07B7);
    expect_reg(2'd1, 16'h0020, 1'b1, "R2 unused enable bits dropped");
    wr_reg(2'd1, 16'hFFFF);
    expect_reg(2'd1, 16'hF868, 1'b1, "R2 enable mask");

    @(negedge clk); modexBusy = 1'b0;
    expect_reg(2'd0, 16'h4000, 1'b0, "R3 modex fall / R9 irq");

    @(negedge clk); txReq = 1'b1;
    expect_reg(2'd0, 16'h4000, 1'b0, "R3 rising tx ignored");

    wr_reg(2'd0, 16'h4000);
    expect_reg(2'd0, 16'h0000, 1'b1, "R7 clear modex");

    @(negedge clk); aesBusy = 1'b0; dmaBusy = 1'b0;
    expect_reg(2'd0, 16'h1020, 1'b0, "R3 aes+dma fall");

    wr_reg(2'd0, 16'h0020);
    expect_reg(2'd0, 16'h1000, 1'b0, "R7 partial clear");

    @(negedge clk); txReq = 1'b0;
    expect_reg(2'd0, 16'h1008, 1'b0, "R3 tx fall");

    @(negedge clk); hashDone = 1'b1;
    @(negedge clk); hashDone = 1'b0;
    expect_reg(2'd0, 16'h3008, 1'b0, "R4 hash pulse");

    wr_reg(2'd0, 16'hFFFF);
    expect_reg(2'd0, 16'h0000, 1'b1, "R7 clear all");

    @(negedge clk); linkUp = 1'b0;
    expect_reg(2'd0, 16'h0800, 1'b0, "R5 link down");
    expect_reg(2'd2, 16'h0000, 1'b0, "R5 status link low");
    wr_reg(2'd0, 16'h0800);
    expect_reg(2'd0, 16'h0000, 1'b1, "R7 clear link");
    @(negedge clk); linkUp = 1'b1;
    expect_reg(2'd0, 16'h0800, 1'b0, "R5 link up");
    wr_reg(2'd0, 16'h0800);

    @(negedge clk); pktCount = 8'd3;
    expect_reg(2'd0, 16'h0040, 1'b0, "R6 packets pending");
    expect_reg(2'd2, 16'h0103, 1'b0, "R5 status count");
    wr_reg(2'd0, 16'hFFFF);
    expect_reg(2'd0, 16'h0040, 1'b0, "R6 write ignored");
    @(negedge clk); pktCount = 8'd0;
    expect_reg(2'd0, 16'h0000, 1'b1, "R6 self clear");

    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0;
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 16'h0008;
    @(negedge clk); regWrEn = 1'b0;
    expect_reg(2'd0, 16'h0008, 1'b0, "R8 set beats clear");

    wr_reg(2'd1, 16'h7868);
    expect_reg(2'd1, 16'h7868, 1'b1, "R10 global off");
    expect_reg(2'd0, 16'h0008, 1'b1, "R10 flag kept, irq gated");
    wr_reg(2'd1, 16'h8000);
    expect_reg(2'd0, 16'h0008, 1'b1, "R9 no individual enable");
    wr_reg(2'd1, 16'h8008);
    expect_reg(2'd0, 16'h0008, 1'b0, "R9 tx enabled");
    wr_reg(2'd1, 16'h0000);
    @(negedge clk); pktCount = 8'd5;
    expect_reg(2'd0, 16'h0048, 1'b1, "R10 all enables off");
    wr_reg(2'd1, 16'h8040);
    expect_reg(2'd0, 16'h0048, 1'b0, "R9 packet enable only");

    @(negedge clk);
    wait (sbq.size() == 0);
    #1;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule